// File: doc/BRIEF.md
# Table Pointer and Table Latch Unit

This block links the data side of a microcontroller with its separate program memory. It holds a wide table pointer, which can reach any program word, and a byte-wide table latch. A table instruction gives a two-bit addressing mode and a function code (idle, read or write). From these the block forms the table address and the next pointer value. For that one cycle it sends the table address to program memory in place of the program counter and tells the fetch logic to hold off. A read loads the program-memory byte at the table address into the latch. A write presents the latch contents to program memory, with a drive enable for the external tri-state buffer.

Software can also load the pointer and the latch directly from the data side, through write enables. Their current values are visible on read-back outputs. When a data-side load arrives in the same cycle as a table operation, the table operation owns both registers.

Top module: `tblptr_unit`

## Requirements
- R1: After reset the table pointer and table latch both read zero.
- R2: When `tbl_func` is idle (00) or reserved (11), `prog_addr` equals `pc_addr`, and both `fetch_hold` and `prog_wr` are 0.
- R3: Mode 00 (`tbl_mode`), with a read or write: `prog_addr` is the current pointer, and the pointer keeps its value after the edge.
- R4: Mode 01, with a read or write: `prog_addr` is the current pointer, and the pointer becomes pointer + 1 after the edge.
- R5: Mode 10, with a read or write: `prog_addr` is the current pointer, and the pointer becomes pointer − 1 after the edge.
- R6: Mode 11, with a read or write: `prog_addr` is pointer + 1, and the pointer takes that same value after the edge.
- R7: A read (`tbl_func` = 01) loads `prog_rdata`, as seen during that cycle, into the latch at the clock edge.
- R8: A write (`tbl_func` = 10) sets `prog_wr` = 1 and puts the latch onto `prog_wdata`, leaving the latch unchanged. In every other cycle `prog_wr` = 0 and `prog_wdata` is all zeros.
- R9: `fetch_hold` is 1 exactly in the cycles where a read or a write is in progress.
- R10: With no read or write in progress, `ptr_we` loads `ptr_wdata` into the pointer and `lat_we` loads `lat_wdata` into the latch at the next edge.
- R11: During a read or write, `ptr_we` and `lat_we` have no effect. The pointer and latch take only the values set by the table operation.
- R12: Pointer arithmetic wraps modulo 2^ADDR_W. All ones + 1 gives zero, and zero − 1 gives all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_addr | input | ADDR_W | Program counter value used for fetch |
| tbl_func | input | 2 | Table function: 00 idle, 01 read, 10 write, 11 reserved (idle) |
| tbl_mode | input | 2 | Addressing mode: 00 hold, 01 post-increment, 10 post-decrement, 11 pre-increment |
| ptr_we | input | 1 | Data-side load enable for the pointer |
| ptr_wdata | input | ADDR_W | Data-side pointer load value |
| lat_we | input | 1 | Data-side load enable for the latch |
| lat_wdata | input | DATA_W | Data-side latch load value |
| prog_rdata | input | DATA_W | Byte returned by program memory at `prog_addr` |
| prog_addr | output | ADDR_W | Program-memory address (PC or table address) |
| prog_wdata | output | DATA_W | Latch contents during a table write, zero otherwise |
| prog_wr | output | 1 | Drive enable for the program data bus (table write) |
| fetch_hold | output | 1 | Suppresses instruction fetch during a table operation |
| tbl_ptr | output | ADDR_W | Current pointer value |
| tbl_lat | output | DATA_W | Current latch value |

## Verification
Two functions can fall in the same cycle: a data-side load of the pointer or latch, and a table read or write that updates the same register. The bench raises both write enables during reads and writes in several modes, and also on reserved-code cycles, where the loads must go through. A scoreboard model gives the table operation priority. After the edge it compares the read-back pointer and latch: they must hold the table result and never the data-side value.

// File: rtl/tblptr_pkg.sv
package tblptr_pkg;
   typedef enum logic [1:0] {
      TF_IDLE  = 2'b00,
      TF_READ  = 2'b01,
      TF_WRITE = 2'b10,
      TF_RSVD  = 2'b11
   } tfunc_e;

   typedef enum logic [1:0] {
      AM_HOLD    = 2'b00,
      AM_POSTINC = 2'b01,
      AM_POSTDEC = 2'b10,
      AM_PREINC  = 2'b11
   } amode_e;
endpackage

// File: rtl/tblptr_addr_gen.sv
module tblptr_addr_gen
   import tblptr_pkg::*;
#(
   parameter int ADDR_W       = 21,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic [ADDR_W-1:0] ptr,
   input  logic [1:0]        mode,
   output logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] ptr_next
);
   localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

   logic [ADDR_W-1:0] inc_v;
   logic [ADDR_W-1:0] dec_v;

   initial assert (ADDR_W >= 2) else $error("ADDR_W must be at least 2");

   generate
      if (SHARED_ADDER) begin : g_shared
         logic [ADDR_W-1:0] step;
         logic [ADDR_W-1:0] sum;
         assign step  = (mode == AM_POSTDEC) ? {ADDR_W{1'b1}} : ONE;
         assign sum   = ptr + step;
         assign inc_v = sum;
         assign dec_v = sum;
      end else begin : g_split
         assign inc_v = ptr + ONE;
         assign dec_v = ptr - ONE;
      end
   endgenerate

   always_comb begin
      unique case (mode)
         AM_POSTINC: ptr_next = inc_v;
         AM_POSTDEC: ptr_next = dec_v;
         AM_PREINC:  ptr_next = inc_v;
         default:    ptr_next = ptr;
      endcase
      addr = (mode == AM_PREINC) ? inc_v : ptr;
   end
endmodule

// File: rtl/tblptr_reg.sv
module tblptr_reg #(
   parameter int          W       = 8,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         pri_load,
   input  logic [W-1:0] pri_data,
   input  logic         sec_load,
   input  logic [W-1:0] sec_data,
   output logic [W-1:0] q
);
   initial assert (W >= 1) else $error("register width must be positive");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= RST_VAL;
      else if (pri_load) q <= pri_data;
      else if (sec_load) q <= sec_data;
   end
endmodule

// File: rtl/tblptr_unit.sv
module tblptr_unit
   import tblptr_pkg::*;
#(
   parameter int ADDR_W       = 21,
   parameter int DATA_W       = 8,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] pc_addr,
   input  logic [1:0]        tbl_func,
   input  logic [1:0]        tbl_mode,
   input  logic              ptr_we,
   input  logic [ADDR_W-1:0] ptr_wdata,
   input  logic              lat_we,
   input  logic [DATA_W-1:0] lat_wdata,
   input  logic [DATA_W-1:0] prog_rdata,
   output logic [ADDR_W-1:0] prog_addr,
   output logic [DATA_W-1:0] prog_wdata,
   output logic              prog_wr,
   output logic              fetch_hold,
   output logic [ADDR_W-1:0] tbl_ptr,
   output logic [DATA_W-1:0] tbl_lat
);
   logic              is_rd;
   logic              is_wr;
   logic              tbl_act;
   logic [ADDR_W-1:0] tbl_addr;
   logic [ADDR_W-1:0] ptr_nxt;

   initial assert (DATA_W >= 1 && DATA_W <= 64) else $error("DATA_W out of range");

   assign is_rd   = (tbl_func == TF_READ);
   assign is_wr   = (tbl_func == TF_WRITE);
   assign tbl_act = is_rd | is_wr;

   tblptr_addr_gen #(.ADDR_W(ADDR_W), .SHARED_ADDER(SHARED_ADDER)) u_agen (
      .ptr      (tbl_ptr),
      .mode     (tbl_mode),
      .addr     (tbl_addr),
      .ptr_next (ptr_nxt)
   );

   tblptr_reg #(.W(ADDR_W)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .pri_load (tbl_act),
      .pri_data (ptr_nxt),
      .sec_load (ptr_we),
      .sec_data (ptr_wdata),
      .q        (tbl_ptr)
   );

   tblptr_reg #(.W(DATA_W)) u_lat (
      .clk      (clk),
      .rst_n    (rst_n),
      .pri_load (tbl_act),
      .pri_data (is_rd ? prog_rdata : tbl_lat),
      .sec_load (lat_we),
      .sec_data (lat_wdata),
      .q        (tbl_lat)
   );

   assign prog_addr  = tbl_act ? tbl_addr : pc_addr;
   assign fetch_hold = tbl_act;
   assign prog_wr    = is_wr;
   assign prog_wdata = is_wr ? tbl_lat : '0;

   AST_IDLE_FOLLOWS_PC: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_hold |-> (prog_addr == pc_addr && !prog_wr)); // R2
   AST_HOLD_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
      (tbl_act && tbl_mode == AM_HOLD) |=> $stable(tbl_ptr)); // R3
   AST_POSTINC_PTR: assert property (@(posedge clk) disable iff (!rst_n)
      (tbl_act && tbl_mode == AM_POSTINC) |=> tbl_ptr == $past(prog_addr) + ADDR_W'(1)); // R4
   AST_POSTDEC_PTR: assert property (@(posedge clk) disable iff (!rst_n)
      (tbl_act && tbl_mode == AM_POSTDEC) |=> tbl_ptr == $past(prog_addr) - ADDR_W'(1)); // R5
   AST_PREINC_ADDR_IS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
      (tbl_act && tbl_mode == AM_PREINC) |=> tbl_ptr == $past(prog_addr)); // R6
   AST_READ_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      is_rd |=> tbl_lat == $past(prog_rdata)); // R7
   AST_WRITE_LATCH_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      is_wr |=> $stable(tbl_lat)); // R8
   AST_WRITE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !prog_wr |-> prog_wdata == '0); // R8
endmodule

// File: tb/sim_tblptr_unit.sv
module sim_tblptr_unit;
   localparam int AW = 21;
   localparam int DW = 8;

   typedef struct {
      string           req;
      logic [AW-1:0]   addr;
      logic            hold;
      logic            wr;
      logic [DW-1:0]   wdata;
      logic [AW-1:0]   ptr;
      logic [DW-1:0]   lat;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] pc_addr = '0;
   logic [1:0]    tbl_func = 2'b00;
   logic [1:0]    tbl_mode = 2'b00;
   logic          ptr_we = 1'b0;
   logic [AW-1:0] ptr_wdata = '0;
   logic          lat_we = 1'b0;
   logic [DW-1:0] lat_wdata = '0;
   logic [DW-1:0] prog_rdata;
   logic [AW-1:0] prog_addr;
   logic [DW-1:0] prog_wdata;
   logic          prog_wr;
   logic          fetch_hold;
   logic [AW-1:0] tbl_ptr;
   logic [DW-1:0] tbl_lat;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;
   exp_t q[$];
   logic [AW-1:0] m_ptr = '0;
   logic [DW-1:0] m_lat = '0;

   always #4 clk = ~clk;

   function automatic logic [DW-1:0] mem_byte(logic [AW-1:0] a);
      return a[7:0] ^ a[15:8] ^ {3'b0, a[20:16]} ^ 8'h5A;
   endfunction

   assign prog_rdata = mem_byte(prog_addr);

   tblptr_unit #(.ADDR_W(AW), .DATA_W(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .pc_addr(pc_addr), .tbl_func(tbl_func),
      .tbl_mode(tbl_mode), .ptr_we(ptr_we), .ptr_wdata(ptr_wdata),
      .lat_we(lat_we), .lat_wdata(lat_wdata), .prog_rdata(prog_rdata),
      .prog_addr(prog_addr), .prog_wdata(prog_wdata), .prog_wr(prog_wr),
      .fetch_hold(fetch_hold), .tbl_ptr(tbl_ptr), .tbl_lat(tbl_lat)
   );

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic step(logic [1:0] f, logic [1:0] m, logic [AW-1:0] pc,
                       logic pwe, logic [AW-1:0] pwd, logic lwe, logic [DW-1:0] lwd,
                       string req);
      exp_t e;
      logic act;
      logic [AW-1:0] a;
      logic [AW-1:0] nxt;
      @(negedge clk);
      tbl_func = f; tbl_mode = m; pc_addr = pc;
      ptr_we = pwe; ptr_wdata = pwd; lat_we = lwe; lat_wdata = lwd;
      act = (f == 2'b01) || (f == 2'b10);
      case (m)
         2'b01: begin a = m_ptr; nxt = m_ptr + 1'b1; end
         2'b10: begin a = m_ptr; nxt = m_ptr - 1'b1; end
         2'b11: begin a = m_ptr + 1'b1; nxt = m_ptr + 1'b1; end
         default: begin a = m_ptr; nxt = m_ptr; end
      endcase
      e.req   = req;
      e.addr  = act ? a : pc;
      e.hold  = act;
      e.wr    = (f == 2'b10);
      e.wdata = (f == 2'b10) ? m_lat : '0;
      if (f == 2'b01)   m_lat = mem_byte(a);
      else if (!act && lwe) m_lat = lwd;
      if (act)          m_ptr = nxt;
      else if (pwe)     m_ptr = pwd;
      e.ptr = m_ptr;
      e.lat = m_lat;
      q.push_back(e);
   endtask

   initial begin : monitor
      exp_t e;
      forever begin
         @(negedge clk);
         #2;
         if (q.size() > 0) begin
            e = q.pop_front();
            chk(e.req, "prog_addr",  64'(prog_addr),  64'(e.addr));
            chk(e.req, "fetch_hold", 64'(fetch_hold), 64'(e.hold));
            chk(e.req, "prog_wr",    64'(prog_wr),    64'(e.wr));
            chk(e.req, "prog_wdata", 64'(prog_wdata), 64'(e.wdata));
            @(posedge clk);
            #2;
            chk(e.req, "tbl_ptr", 64'(tbl_ptr), 64'(e.ptr));
            chk(e.req, "tbl_lat", 64'(tbl_lat), 64'(e.lat));
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin : watchdog
      #(8 * 200000);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin : driver
      repeat (3) @(negedge clk);
      // R1: reset values
      chk("R1", "tbl_ptr reset", 64'(tbl_ptr), 64'd0);
      chk("R1", "tbl_lat reset", 64'(tbl_lat), 64'd0);
      rst_n = 1'b1;
      // R2: idle and reserved codes follow PC
      step(2'b00, 2'b11, 21'h00ABC, 1'b0, '0, 1'b0, '0, "R2");
      step(2'b11, 2'b01, 21'h1F00F, 1'b0, '0, 1'b0, '0, "R2_rsvd");
      // R10: data-side loads when idle, including on the reserved code
      step(2'b00, 2'b00, 21'h00010, 1'b1, 21'h12345, 1'b1, 8'hC3, "R10");
      step(2'b11, 2'b10, 21'h00011, 1'b1, 21'h10000, 1'b0, '0, "R10_rsvd");
      // R3..R6 with reads (R7, R9)
      step(2'b01, 2'b00, 21'h00020, 1'b0, '0, 1'b0, '0, "R3");
      step(2'b01, 2'b01, 21'h00021, 1'b0, '0, 1'b0, '0, "R4");
      step(2'b01, 2'b01, 21'h00022, 1'b0, '0, 1'b0, '0, "R4_again");
      step(2'b01, 2'b10, 21'h00023, 1'b0, '0, 1'b0, '0, "R5");
      step(2'b01, 2'b11, 21'h00024, 1'b0, '0, 1'b0, '0, "R6");
      step(2'b01, 2'b00, 21'h00025, 1'b0, '0, 1'b0, '0, "R7");
      // R8: writes in each mode, latch unchanged
      step(2'b00, 2'b00, 21'h00030, 1'b0, '0, 1'b1, 8'hA5, "R10_lat");
      step(2'b10, 2'b00, 21'h00031, 1'b0, '0, 1'b0, '0, "R8_hold");
      step(2'b10, 2'b01, 21'h00032, 1'b0, '0, 1'b0, '0, "R8_postinc");
      step(2'b10, 2'b10, 21'h00033, 1'b0, '0, 1'b0, '0, "R8_postdec");
      step(2'b10, 2'b11, 21'h00034, 1'b0, '0, 1'b0, '0, "R8_preinc");
      step(2'b00, 2'b00, 21'h00035, 1'b0, '0, 1'b0, '0, "R9_idle");
      // R11: collisions, table operation wins
      step(2'b01, 2'b01, 21'h00040, 1'b1, 21'h0BEEF, 1'b1, 8'h11, "R11_read");
      step(2'b10, 2'b11, 21'h00041, 1'b1, 21'h0CAFE, 1'b1, 8'h22, "R11_write");
      step(2'b01, 2'b00, 21'h00042, 1'b1, 21'h00777, 1'b1, 8'h33, "R11_hold");
      // R12: wraparound
      step(2'b00, 2'b00, 21'h00050, 1'b1, 21'h1FFFFF, 1'b0, '0, "R12_load");
      step(2'b01, 2'b11, 21'h00051, 1'b0, '0, 1'b0, '0, "R12_preinc_wrap");
      step(2'b01, 2'b10, 21'h00052, 1'b0, '0, 1'b0, '0, "R12_postdec_wrap");
      step(2'b10, 2'b01, 21'h00053, 1'b0, '0, 1'b0, '0, "R12_postinc_wrap");
      step(2'b00, 2'b00, 21'h1FFFFE, 1'b0, '0, 1'b0, '0, "R2_end");
      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule